// File: doc/BRIEF.md
# Branch Target Stream Fetch

This block is the instruction fetch front end of a core whose code lives in a separate, read-only page-mode DRAM. It hands the core one 32-bit instruction word per cycle, tagged with its word address. While fetch runs straight ahead inside an open DRAM row, every word comes from a cheap page-mode access. A taken branch, or a sequential fetch that runs off the end of a row, forces a slow random access.

To hide that latency after a branch, the block keeps a small fully associative store. Each entry holds the word address of a branch target and the first few instructions found there. When a redirect hits, the block issues the stored words at once. At the same moment it asks the DRAM for the word just past the stored run, so DRAM streaming takes over without a gap, a duplicate or a skip. When a redirect misses, the block waits for the DRAM and copies the first words that arrive into an entry chosen in round-robin order.

The DRAM port works as follows. A one-cycle request carries a start address. The memory then presents words in address order with a ready flag, and holds each word until the block acknowledges it. The memory stops at the end of its row, and the block issues the next request itself.

Top module: `bts_fetch`

## Requirements
- R1: From reset until the first redirect, `instr_valid` and `mem_req` stay low.
- R2: Within one stream, each issued word has the address one above the previous issued word, and its data is the memory content at that address.
- R3: On a redirect whose target is held valid in the store, the word at the target is issued in the next cycle. The following WORDS-1 stored words follow one per cycle.
- R4: On such a hit, `mem_req` is raised in the next cycle with address target+WORDS. Words issued after the stored run continue from target+WORDS.
- R5: On a redirect that misses, `mem_req` is raised in the next cycle with the target address, and `instr_valid` stays low until the memory shows ready. With a memory latency of L cycles, the first word is issued L+1 cycles after the redirect.
- R6: A row holds PAGE_WORDS words (default 16, so a row ends at an address whose low 4 bits are all ones). When the last word of a row is accepted from memory, `mem_req` is raised in the next cycle for the following address. Nothing is issued until that word returns.
- R7: On a miss, the first WORDS words accepted from memory are written into the allocated entry, which becomes valid only once all of them are stored. At most one entry matches any target.
- R8: Entries (ENTRIES, default 32) are allocated in strict round-robin order over all slots. A hit does not move the pointer.
- R9: A redirect in any state abandons the current stream. The next cycle issues nothing, or the new target's word. An entry whose fill was cut short never hits.
- R10: `mem_ack` is high only in a cycle where a memory word is issued on the output, and it accepts that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | One-cycle redirect strobe |
| br_target | input | AW | Redirect word address |
| instr_valid | output | 1 | Issued word is valid this cycle |
| instr_data | output | DW | Issued instruction word |
| instr_pc | output | AW | Word address of the issued word |
| mem_req | output | 1 | Start a random access (one cycle) |
| mem_addr | output | AW | Start address of the random access |
| mem_rdy | input | 1 | Memory presents a word |
| mem_rdata | input | DW | Word presented by memory |
| mem_ack | output | 1 | Presented word is accepted |

## Verification
The properties assume that `br_valid` is a clean pulse, and that the memory returns words strictly in address order from the last requested address. They also assume the memory holds a word until it is acknowledged, and stops presenting words after the last word of a row. The bench's memory model follows this contract exactly: it reloads on every request, waits a fixed latency, and goes quiet at row ends. Redirects are driven only between clock edges, with at least one idle cycle between them.

// File: rtl/bts_pkg.sv
package bts_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_DRAM = 2'd2
    } fetch_st_e;

endpackage

// File: rtl/bts_lookup.sv
module bts_lookup #(
    parameter int AW      = 16,
    parameter int ENTRIES = 32,
    parameter int IW      = 5
) (
    input  logic [AW-1:0]               key,
    input  logic [ENTRIES-1:0][AW-1:0]  tags,
    input  logic [ENTRIES-1:0]          valids,
    output logic [ENTRIES-1:0]          match,
    output logic                        hit,
    output logic [IW-1:0]               idx
);

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
        assign match[gi] = valids[gi] && (tags[gi] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) idx = idx | IW'(i);
        end
        hit = |match;
    end

endmodule

// File: rtl/bts_store.sv
module bts_store #(
    parameter int AW      = 16,
    parameter int DW      = 32,
    parameter int WORDS   = 4,
    parameter int ENTRIES = 32,
    parameter int IW      = 5,
    parameter int CW      = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc_en,
    input  logic [IW-1:0]               alloc_idx,
    input  logic [AW-1:0]               alloc_tag,
    input  logic                        wr_en,
    input  logic [IW-1:0]               wr_idx,
    input  logic [CW-1:0]               wr_word,
    input  logic [DW-1:0]               wr_data,
    input  logic                        val_set,
    input  logic [IW-1:0]               rd_idx,
    input  logic [CW-1:0]               rd_word,
    output logic [DW-1:0]               rd_data,
    output logic [ENTRIES-1:0][AW-1:0]  tags,
    output logic [ENTRIES-1:0]          valids
);

    logic [DW-1:0] words_q [ENTRIES][WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valids <= '0;
        end else begin
            if (alloc_en) valids[alloc_idx] <= 1'b0;
            if (val_set)  valids[wr_idx]    <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_en) tags[alloc_idx] <= alloc_tag;
        if (wr_en)    words_q[wr_idx][wr_word] <= wr_data;
    end

    assign rd_data = words_q[rd_idx][rd_word];

endmodule

// File: rtl/bts_fetch.sv
module bts_fetch
    import bts_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int WORDS      = 4,
    parameter int ENTRIES    = 32,
    parameter int PAGE_WORDS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          br_valid,
    input  logic [AW-1:0] br_target,
    output logic          instr_valid,
    output logic [DW-1:0] instr_data,
    output logic [AW-1:0] instr_pc,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rdy,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_ack
);

    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int PB = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1;

    typedef struct packed {
        fetch_st_e     st;
        logic [AW-1:0] pc;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic          fill_on;
        logic [IW-1:0] fill_idx;
        logic [CW-1:0] fill_cnt;
        logic [IW-1:0] rr;
        logic          req;
        logic [AW-1:0] req_addr;
    } fetch_regs_t;

    fetch_regs_t q, d;

    logic [ENTRIES-1:0][AW-1:0] st_tags;
    logic [ENTRIES-1:0]         st_valids;
    logic [ENTRIES-1:0]         lk_match;
    logic                       lk_hit;
    logic [IW-1:0]              lk_idx;
    logic [DW-1:0]              rd_data;
    logic                       alloc_en, wr_en, val_set, from_dram;

    bts_lookup #(.AW(AW), .ENTRIES(ENTRIES), .IW(IW)) u_lookup (
        .key    (br_target),
        .tags   (st_tags),
        .valids (st_valids),
        .match  (lk_match),
        .hit    (lk_hit),
        .idx    (lk_idx)
    );

    bts_store #(.AW(AW), .DW(DW), .WORDS(WORDS), .ENTRIES(ENTRIES), .IW(IW), .CW(CW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (alloc_en),
        .alloc_idx (q.rr),
        .alloc_tag (br_target),
        .wr_en     (wr_en),
        .wr_idx    (q.fill_idx),
        .wr_word   (q.fill_cnt),
        .wr_data   (mem_rdata),
        .val_set   (val_set),
        .rd_idx    (q.idx),
        .rd_word   (q.cnt),
        .rd_data   (rd_data),
        .tags      (st_tags),
        .valids    (st_valids)
    );

    always_comb begin
        d         = q;
        d.req     = 1'b0;
        alloc_en  = 1'b0;
        wr_en     = 1'b0;
        val_set   = 1'b0;
        // stale words during a fresh request belong to the abandoned stream
        from_dram   = (q.st == ST_DRAM) && mem_rdy && !q.req;
        instr_valid = (q.st == ST_HIT) || from_dram;
        instr_data  = (q.st == ST_HIT) ? rd_data : mem_rdata;
        mem_ack     = from_dram;

        if (br_valid) begin
            d.pc      = br_target;
            d.cnt     = '0;
            d.req     = 1'b1;
            d.fill_on = 1'b0;
            if (lk_hit) begin
                d.st       = ST_HIT;
                d.idx      = lk_idx;
                d.req_addr = br_target + AW'(WORDS);
            end else begin
                d.st       = ST_DRAM;
                d.req_addr = br_target;
                alloc_en   = 1'b1;
                d.fill_on  = 1'b1;
                d.fill_idx = q.rr;
                d.fill_cnt = '0;
                d.rr       = (q.rr == IW'(ENTRIES - 1)) ? '0 : q.rr + 1'b1;
            end
        end else if (q.st == ST_HIT) begin
            d.pc = q.pc + 1'b1;
            if (q.cnt == CW'(WORDS - 1)) begin
                d.st  = ST_DRAM;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else if (from_dram) begin
            d.pc = q.pc + 1'b1;
            if (q.fill_on) begin
                wr_en = 1'b1;
                if (q.fill_cnt == CW'(WORDS - 1)) begin
                    val_set   = 1'b1;
                    d.fill_on = 1'b0;
                end else begin
                    d.fill_cnt = q.fill_cnt + 1'b1;
                end
            end
            if (q.pc[PB-1:0] == '1) begin
                d.req      = 1'b1;
                d.req_addr = q.pc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign instr_pc = q.pc;
    assign mem_req  = q.req;
    assign mem_addr = q.req_addr;

endmodule

// File: rtl/bts_fetch_chk.sv
module bts_fetch_chk #(
    parameter int AW         = 16,
    parameter int WORDS      = 4,
    parameter int ENTRIES    = 32,
    parameter int PAGE_WORDS = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               br_valid,
    input logic [AW-1:0]      br_target,
    input logic               instr_valid,
    input logic [AW-1:0]      instr_pc,
    input logic               mem_req,
    input logic [AW-1:0]      mem_addr,
    input logic               mem_rdy,
    input logic               mem_ack,
    input logic               hit,
    input logic [ENTRIES-1:0] match
);

    localparam int PB = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1;

    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        seen_q <= 1'b0;
        else if (br_valid) seen_q <= 1'b1;
    end

    assert_quiet_before_branch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (!instr_valid && !mem_req));

    assert_stream_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !br_valid) |=> (!instr_valid || instr_pc == AW'($past(instr_pc) + 1'b1)));

    assert_hit_first_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && hit) |=> (instr_valid && instr_pc == $past(br_target)));

    assert_hit_resume_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && hit) |=> (mem_req && mem_addr == AW'($past(br_target) + AW'(WORDS))));

    assert_miss_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !hit) |=> (mem_req && mem_addr == $past(br_target) && !instr_valid));

    assert_row_end_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ack && !br_valid && instr_pc[PB-1:0] == '1) |=>
            (mem_req && mem_addr == AW'($past(instr_pc) + 1'b1)));

    assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> (!instr_valid || instr_pc == $past(br_target)));

    assert_ack_pairing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ack |-> (instr_valid && mem_rdy && !mem_req));

endmodule

bind bts_fetch bts_fetch_chk #(
    .AW(AW), .WORDS(WORDS), .ENTRIES(ENTRIES), .PAGE_WORDS(PAGE_WORDS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .br_valid    (br_valid),
    .br_target   (br_target),
    .instr_valid (instr_valid),
    .instr_pc    (instr_pc),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_rdy     (mem_rdy),
    .mem_ack     (mem_ack),
    .hit         (lk_hit),
    .match       (lk_match)
);

// File: tb/bts_fetch_tb.sv
module bts_fetch_tb;

    localparam int AW    = 16;
    localparam int LAT   = 3;
    localparam int WORDS = 4;
    localparam int NVEC  = 8;

    typedef struct packed {
        logic [15:0] tgt;
        logic        hit;
        logic [7:0]  cyc;
    } vec_t;

    // stimulus: redirect target; expected: hit or miss, cycles observed
    localparam vec_t TBL [NVEC] = '{
        '{16'h0100, 1'b0, 8'd12},
        '{16'h0200, 1'b0, 8'd12},
        '{16'h0100, 1'b1, 8'd12},
        '{16'h0200, 1'b1, 8'd12},
        '{16'h013D, 1'b0, 8'd14},
        '{16'h013D, 1'b1, 8'd14},
        '{16'h010D, 1'b0, 8'd14},
        '{16'h010D, 1'b1, 8'd10}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          br_valid;
    logic [AW-1:0] br_target;
    logic          instr_valid;
    logic [31:0]   instr_data;
    logic [AW-1:0] instr_pc;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_rdy;
    logic [31:0]   mem_rdata;
    logic          mem_ack;

    always #5 clk = ~clk;

    function automatic logic [31:0] word_of(logic [15:0] a);
        return {a ^ 16'hA5C3, a};
    endfunction

    bts_fetch #(.AW(AW), .DW(32), .WORDS(WORDS), .ENTRIES(32), .PAGE_WORDS(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_target(br_target),
        .instr_valid(instr_valid), .instr_data(instr_data), .instr_pc(instr_pc),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdy(mem_rdy),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // memory model: reload on request, fixed latency, quiet after row end
    logic          dr_act;
    int            dr_wait;
    logic [AW-1:0] dr_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr_act  <= 1'b0;
            dr_wait <= 0;
            dr_addr <= '0;
        end else if (mem_req) begin
            dr_act  <= 1'b1;
            dr_wait <= LAT - 1;
            dr_addr <= mem_addr;
        end else if (dr_act) begin
            if (dr_wait > 0) dr_wait <= dr_wait - 1;
            else if (mem_ack) begin
                dr_addr <= dr_addr + 1'b1;
                if (dr_addr[3:0] == 4'hF) dr_act <= 1'b0;
            end
        end
    end

    assign mem_rdy   = dr_act && (dr_wait == 0);
    assign mem_rdata = word_of(dr_addr);

    int n_run = 0, n_fail = 0;
    int first_off, seq_err, words, ack_err = 0;

    task automatic check_eq(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic watch(input logic [15:0] t, input int cyc);
        logic [15:0] expc;
        expc = t; first_off = -1; seq_err = 0; words = 0;
        br_valid = 1'b1; br_target = t;
        @(negedge clk);
        br_valid = 1'b0;
        for (int k = 1; k <= cyc; k++) begin
            if (instr_valid) begin
                if (first_off < 0) first_off = k;
                if (instr_pc != expc || instr_data != word_of(expc)) seq_err++;
                expc++;
                words++;
            end
            if (mem_ack && !(instr_valid && dr_addr == instr_pc)) ack_err++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int loop_bad;
        rst_n = 1'b0; br_valid = 1'b0; br_target = '0;
        repeat (3) @(negedge clk);
        check_eq("R1 valid in reset", int'(instr_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R1 valid idle", int'(instr_valid), 0);
        check_eq("R1 request idle", int'(mem_req), 0);

        for (int i = 0; i < NVEC; i++) begin
            watch(TBL[i].tgt, int'(TBL[i].cyc));
            if (TBL[i].hit) check_eq("R3 hit first-word cycle", first_off, 1);
            else            check_eq("R5 miss first-word cycle", first_off, LAT + 1);
            check_eq("R2/R4/R6 stream order", seq_err, 0);
            check_eq("R7 enough words to fill", int'(words >= WORDS), 1);
        end

        // cancel a pending miss with a redirect that hits
        br_valid = 1'b1; br_target = 16'h0300;
        @(negedge clk);
        br_valid = 1'b0;
        @(negedge clk);
        watch(16'h0100, 8);
        check_eq("R9 cancel pending miss", first_off, 1);
        check_eq("R9 no stale words", seq_err, 0);
        watch(16'h0300, 10);
        check_eq("R9 cut fill never hits", first_off, LAT + 1);
        // cancel a stream served from the store
        watch(16'h0100, 2);
        watch(16'h0200, 8);
        check_eq("R9 cancel hit stream", first_off, 1);
        check_eq("R9 order after cancel", seq_err, 0);

        // 32 new targets refill every slot in round-robin order
        loop_bad = 0;
        for (int i = 0; i < 32; i++) begin
            watch(16'h0800 + 16'(8 * i), 10);
            if (first_off != LAT + 1 || seq_err != 0) loop_bad++;
        end
        check_eq("R8 fresh targets miss", loop_bad, 0);
        watch(16'h0800, 6);
        check_eq("R8 oldest fill still held", first_off, 1);
        watch(16'h0100, 10);
        check_eq("R8 early entry evicted", first_off, LAT + 1);
        watch(16'h0800, 10);
        check_eq("R8 pointer victim after hit", first_off, LAT + 1);

        check_eq("R10 ack pairs with issued word", ack_err, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule